// File: doc/BRIEF.md
# Ping-Pong Line Receive Deframer

This block sits behind the slicer of a two-wire burst-mode line. Each accepted symbol is either a space (no pulse) or a mark, and a mark carries a polarity. The line is silent between bursts. The deframer waits for a run of silence and takes the first mark after it as the framing bit. It then counts the rest of the burst and reports whether the framing bit broke the alternate-polarity rule. It also pulls out the one multiframe bit that every frame carries and passes it to the backplane side.

Four frames form a multiframe. A polarity violation in a frame's multiframe slot marks the first frame of a multiframe and restarts the frame position counter. One frame position inside the multiframe carries the T-bit. The deframer latches that bit and presents it in the backplane multiframe slot of every frame, not only in the frame that brought it. A burst that falls silent early is reported as an error, and the deframer then waits for the next framing bit. A missing multiframe marker where one is expected raises a loss flag.

Top module: `ping_pong_deframer`

## Requirements
- R1: A mark is taken as the framing bit (frame position 0) only after at least SIL_LEN (default 4) consecutive accepted space symbols. A mark that comes earlier is not a framing bit and restarts the silence count.
- R2: On the edge that accepts the framing bit, rx_sta becomes 2'b01 if the mark is not a violation, or 2'b10 if it is a violation.
- R3: A mark is a violation when its polarity (sym_pos) equals the polarity of the previous accepted mark, even if that mark came in an earlier burst. After reset, the previous polarity is taken as 0.
- R4: If SIL_LEN consecutive spaces are accepted inside a frame before its last position (FRAME_LEN-1, default 11), rx_sta becomes 2'b11 on that edge. The deframer then takes the next mark as a framing bit without waiting for further silence.
- R5: One cycle after the symbol at frame position M_SLOT (default 2) is accepted, mslot_vld is high for one cycle and mslot_mbit equals that symbol's magnitude (1 = mark). mslot_vld is low at every other position.
- R6: mf_start pulses together with mslot_vld when the multiframe-slot symbol is a violating mark. That frame becomes multiframe index 0.
- R7: Once the deframer is synchronised, the multiframe-slot bit of the frame at multiframe index T_IDX (default 2) is latched as the T-bit. mslot_tbit shows the latched T-bit in every frame and changes only with mslot_vld.
- R8: mf_lost is set when a synchronised frame at multiframe index 0 carries no violation in its multiframe slot. A later detected multiframe violation clears it.
- R9: After reset, rx_sta is 2'b00 and mslot_vld, mslot_mbit, mslot_tbit, mf_start and mf_lost are all 0.
- R10: Cycles with sym_en low have no effect on the deframer, whatever the values of sym_mark and sym_pos.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sym_en | input | 1 | Symbol enable; the symbol is accepted on this edge |
| sym_mark | input | 1 | Symbol magnitude: 1 = mark, 0 = space |
| sym_pos | input | 1 | Polarity of a mark |
| rx_sta | output | 2 | Receive status: 00 none, 01 framing bit normal, 10 framing bit violation, 11 short burst |
| mslot_vld | output | 1 | One-cycle strobe after the multiframe slot of a frame |
| mslot_mbit | output | 1 | Multiframe bit extracted from the line |
| mslot_tbit | output | 1 | Latched T-bit presented in each frame's backplane multiframe slot |
| mf_start | output | 1 | Multiframe start marker seen in this frame |
| mf_lost | output | 1 | Expected multiframe marker missing |

## Verification
Frames are sent with every mix of framing-bit violation, multiframe-bit value and marker placement over several multiframes. Idle cycles with junk marks sit between the symbols, so a design that reads symbols while sym_en is low shows it. The polarity reference carries over between bursts, which tells a correct violation rule apart from one that resets at each burst. Silence runs one space short of SIL_LEN test the framing-bit detection from both sides. A short burst followed at once by a frame shows the return to the armed state. A missing marker followed by a marker in an unexpected frame shows that the loss flag is set, that it is cleared, and that the multiframe counter resynchronises.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic [1:0] {
    ST_SIL = 2'd0,
    ST_ARM = 2'd1,
    ST_FRM = 2'd2
  } dfr_state_e;

  typedef enum logic [1:0] {
    RS_NONE   = 2'b00,
    RS_NORMAL = 2'b01,
    RS_VIOL   = 2'b10,
    RS_SHORT  = 2'b11
  } rx_sta_e;
endpackage

// File: rtl/dfr_polarity.sv
module dfr_polarity (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_en,
  input  logic sym_mark,
  input  logic sym_pos,
  output logic viol
);
  logic last_pol_q, last_pol_d;

  // a mark repeating the previous mark's polarity breaks alternation
  assign viol = sym_mark && (sym_pos == last_pol_q);

  always_comb begin
    last_pol_d = last_pol_q;
    if (sym_en && sym_mark) last_pol_d = sym_pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_pol_q <= 1'b0;
    else        last_pol_q <= last_pol_d;
  end

  a_r3_pol_follows_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && sym_mark) |=> (last_pol_q == $past(sym_pos)));
endmodule

// File: rtl/dfr_frame_ctl.sv
module dfr_frame_ctl
  import dfr_pkg::*;
#(
  parameter int FRAME_LEN = 12,
  parameter int SIL_LEN   = 4,
  parameter int M_SLOT    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_en,
  input  logic       sym_mark,
  input  logic       viol,
  output logic [1:0] rx_sta,
  output logic       m_stb,
  output logic       m_mark,
  output logic       m_cv
);
  localparam int ZW = $clog2(SIL_LEN + 1);
  localparam int BW = $clog2(FRAME_LEN);
  localparam logic [ZW-1:0] ZLIM = ZW'(SIL_LEN);
  localparam logic [BW-1:0] LAST = BW'(FRAME_LEN - 1);
  localparam logic [BW-1:0] MPOS = BW'(M_SLOT);

  dfr_state_e      state_q, state_d;
  logic [ZW-1:0]   zrun_q, zrun_d, zrun_inc;
  logic [BW-1:0]   bidx_q, bidx_d;
  rx_sta_e         sta_q, sta_d;

  assign zrun_inc = (zrun_q == ZLIM) ? zrun_q : zrun_q + 1'b1;
  assign m_mark   = sym_mark;
  assign m_cv     = viol;
  assign rx_sta   = sta_q;

  always_comb begin
    state_d = state_q;
    zrun_d  = zrun_q;
    bidx_d  = bidx_q;
    sta_d   = sta_q;
    m_stb   = 1'b0;
    if (sym_en) begin
      unique case (state_q)
        ST_SIL: begin
          if (sym_mark) zrun_d = '0;
          else begin
            zrun_d = zrun_inc;
            if (zrun_inc == ZLIM) state_d = ST_ARM;
          end
        end
        ST_ARM: begin
          if (sym_mark) begin
            state_d = ST_FRM;
            bidx_d  = BW'(1);
            zrun_d  = '0;
            sta_d   = viol ? RS_VIOL : RS_NORMAL;
          end
        end
        ST_FRM: begin
          m_stb  = (bidx_q == MPOS);
          zrun_d = sym_mark ? '0 : zrun_inc;
          if (bidx_q == LAST) begin
            state_d = ST_SIL;
            zrun_d  = '0;
          end else if (!sym_mark && zrun_inc == ZLIM) begin
            state_d = ST_ARM;
            sta_d   = RS_SHORT;
          end else begin
            bidx_d = bidx_q + 1'b1;
          end
        end
        default: state_d = ST_SIL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SIL;
      zrun_q  <= '0;
      bidx_q  <= '0;
      sta_q   <= RS_NONE;
    end else begin
      state_q <= state_d;
      zrun_q  <= zrun_d;
      bidx_q  <= bidx_d;
      sta_q   <= sta_d;
    end
  end

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_en |=> ($stable(state_q) && $stable(sta_q) && $stable(bidx_q)));
  a_r2_lf_status: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM && sym_en && sym_mark) |=>
      (sta_q == RS_NORMAL || sta_q == RS_VIOL) && state_q == ST_FRM);
  a_r1_no_frame_from_sil: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SIL) |=> (state_q != ST_FRM));
  a_r4_short_goes_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FRM && sta_q != RS_SHORT && sta_d == RS_SHORT) |=> (state_q == ST_ARM));
endmodule

// File: rtl/dfr_mframe.sv
module dfr_mframe #(
  parameter int MF_LEN = 4,
  parameter int T_IDX  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m_stb,
  input  logic m_mark,
  input  logic m_cv,
  output logic mslot_vld,
  output logic mslot_mbit,
  output logic mslot_tbit,
  output logic mf_start,
  output logic mf_lost
);
  localparam int IW = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
  localparam logic [IW-1:0] IMAX = IW'(MF_LEN - 1);
  localparam logic [IW-1:0] TPOS = IW'(T_IDX);

  logic [IW-1:0] idx_q, idx_d, idx_nxt;
  logic          sync_q, sync_d;
  logic          lost_q, lost_d;
  logic          tbit_q, tbit_d;
  logic          vld_q, vld_d, mbit_q, mbit_d, start_q, start_d;

  assign idx_nxt = (idx_q == IMAX) ? '0 : idx_q + 1'b1;

  always_comb begin
    idx_d   = idx_q;
    sync_d  = sync_q;
    lost_d  = lost_q;
    tbit_d  = tbit_q;
    vld_d   = m_stb;
    mbit_d  = m_stb ? m_mark : mbit_q;
    start_d = m_stb && m_cv;
    if (m_stb) begin
      if (m_cv) begin
        idx_d  = '0;
        sync_d = 1'b1;
        lost_d = 1'b0;
      end else if (sync_q) begin
        idx_d = idx_nxt;
        if (idx_nxt == '0) lost_d = 1'b1;
        if (idx_nxt == TPOS) tbit_d = m_mark;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      sync_q  <= 1'b0;
      lost_q  <= 1'b0;
      tbit_q  <= 1'b0;
      vld_q   <= 1'b0;
      mbit_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      sync_q  <= sync_d;
      lost_q  <= lost_d;
      tbit_q  <= tbit_d;
      vld_q   <= vld_d;
      mbit_q  <= mbit_d;
      start_q <= start_d;
    end
  end

  assign mslot_vld  = vld_q;
  assign mslot_mbit = mbit_q;
  assign mslot_tbit = tbit_q;
  assign mf_start   = start_q;
  assign mf_lost    = lost_q;

  a_r5_slot_single: assert property (@(posedge clk) disable iff (!rst_n)
    mslot_vld |=> !mslot_vld);
  a_r6_start_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> mslot_vld);
  a_r8_start_clears_lost: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> !mf_lost);
  a_r7_tbit_held: assert property (@(posedge clk) disable iff (!rst_n)
    !mslot_vld |-> $stable(mslot_tbit));
endmodule

// File: rtl/ping_pong_deframer.sv
module ping_pong_deframer #(
  parameter int FRAME_LEN = 12,
  parameter int SIL_LEN   = 4,
  parameter int M_SLOT    = 2,
  parameter int MF_LEN    = 4,
  parameter int T_IDX     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_en,
  input  logic       sym_mark,
  input  logic       sym_pos,
  output logic [1:0] rx_sta,
  output logic       mslot_vld,
  output logic       mslot_mbit,
  output logic       mslot_tbit,
  output logic       mf_start,
  output logic       mf_lost
);
  logic rs1_q, rs2_q;
  logic viol, m_stb, m_mark, m_cv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  dfr_polarity u_pol (
    .clk(clk), .rst_n(rs2_q), .sym_en(sym_en), .sym_mark(sym_mark),
    .sym_pos(sym_pos), .viol(viol)
  );

  dfr_frame_ctl #(.FRAME_LEN(FRAME_LEN), .SIL_LEN(SIL_LEN), .M_SLOT(M_SLOT)) u_ctl (
    .clk(clk), .rst_n(rs2_q), .sym_en(sym_en), .sym_mark(sym_mark), .viol(viol),
    .rx_sta(rx_sta), .m_stb(m_stb), .m_mark(m_mark), .m_cv(m_cv)
  );

  dfr_mframe #(.MF_LEN(MF_LEN), .T_IDX(T_IDX)) u_mf (
    .clk(clk), .rst_n(rs2_q), .m_stb(m_stb), .m_mark(m_mark), .m_cv(m_cv),
    .mslot_vld(mslot_vld), .mslot_mbit(mslot_mbit), .mslot_tbit(mslot_tbit),
    .mf_start(mf_start), .mf_lost(mf_lost)
  );
endmodule

// File: tb/ping_pong_deframer_tb.sv
module ping_pong_deframer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FL = 12;
  localparam int SL = 4;
  localparam int MP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_en = 1'b0, sym_mark = 1'b0, sym_pos = 1'b0;
  logic [1:0] rx_sta;
  logic mslot_vld, mslot_mbit, mslot_tbit, mf_start, mf_lost;

  int checks = 0;
  int errors = 0;
  logic last_pol = 1'b0;
  int gap_ctr = 0;
  logic cur_t = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ping_pong_deframer #(.FRAME_LEN(FL), .SIL_LEN(SL), .M_SLOT(MP)) u_dut (
    .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .sym_mark(sym_mark), .sym_pos(sym_pos),
    .rx_sta(rx_sta), .mslot_vld(mslot_vld), .mslot_mbit(mslot_mbit),
    .mslot_tbit(mslot_tbit), .mf_start(mf_start), .mf_lost(mf_lost)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic en, input logic mk, input logic pl);
    @(negedge clk);
    sym_en = en; sym_mark = mk; sym_pos = pl;
    @(negedge clk);
    sym_en = 1'b0;
  endtask

  // R10: junk marks on disabled cycles between many symbols
  task automatic put(input logic mk, input logic pl);
    gap_ctr++;
    if (gap_ctr % 3 != 0) cyc(1'b0, 1'b1, gap_ctr[1]);
    cyc(1'b1, mk, pl);
    if (mk) last_pol = pl;
  endtask

  task automatic put_mark(input logic v);
    put(1'b1, v ? last_pol : ~last_pol);
  endtask

  task automatic silence(input int n);
    for (int k = 0; k < n; k++) put(1'b0, 1'b0);
  endtask

  task automatic frame(input logic lfv, input logic mv, input logic mcv,
                       input logic e_start, input logic e_t, input logic e_lost);
    put_mark(lfv);
    chk("R2 R3 framing status", rx_sta, lfv ? 2 : 1);
    for (int b = 1; b < FL; b++) begin
      if (b == MP) begin
        if (mv) put_mark(mcv); else put(1'b0, 1'b0);
        chk("R5 slot valid", mslot_vld, 1);
        chk("R5 mbit", mslot_mbit, mv);
        chk("R6 mf_start", mf_start, e_start);
        chk("R7 tbit", mslot_tbit, e_t);
        chk("R8 mf_lost", mf_lost, e_lost);
      end else begin
        put_mark(1'b0);
        if (b == MP + 1 || b == FL - 1) chk("R5 no slot", mslot_vld, 0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] prev;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 rx_sta", rx_sta, 0);
    chk("R9 mslot_vld", mslot_vld, 0);
    chk("R9 mbit", mslot_mbit, 0);
    chk("R9 tbit", mslot_tbit, 0);
    chk("R9 start", mf_start, 0);
    chk("R9 lost", mf_lost, 0);

    // R4: short burst, then an immediate frame without silence
    silence(SL);
    put_mark(1'b0);
    chk("R2 first LF", rx_sta, 1);
    silence(SL - 1);
    chk("R4 not yet short", rx_sta, 1);
    put(1'b0, 1'b0);
    chk("R4 short burst", rx_sta, 3);
    frame(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    // R1: silence one short of SL does not arm
    silence(SL - 1);
    put_mark(1'b0);
    chk("R1 early mark ignored", rx_sta, 2);
    silence(SL - 1);
    put_mark(1'b0);
    chk("R1 early mark ignored again", rx_sta, 2);
    silence(SL);
    // R10: disabled cycles with marks while armed
    prev = rx_sta;
    for (int k = 0; k < 5; k++) cyc(1'b0, 1'b1, k[0]);
    chk("R10 disabled marks ignored", rx_sta, prev);
    frame(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    silence(SL);

    // sweep of synchronised multiframes
    for (int i = 0; i < 24; i++) begin
      logic lfv, mv, mcv;
      lfv = (i % 3 == 1);
      if (i % 4 == 0) begin mv = 1'b1; mcv = 1'b1; end
      else if (i % 4 == 2) begin mv = ((i / 4) % 2 == 1); mcv = 1'b0; cur_t = mv; end
      else begin mv = ((i >> 3) & 1) == 1; mcv = 1'b0; end
      frame(lfv, mv, mcv, mcv, cur_t, 1'b0);
      silence(SL);
    end

    // R8: missing marker, loss, then resync at an unexpected frame
    frame(1'b0, 1'b1, 1'b0, 1'b0, cur_t, 1'b1); silence(SL);
    frame(1'b1, 1'b0, 1'b0, 1'b0, cur_t, 1'b1); silence(SL);
    cur_t = ~cur_t;
    frame(1'b0, cur_t, 1'b0, 1'b0, cur_t, 1'b1); silence(SL);
    frame(1'b0, 1'b1, 1'b1, 1'b1, cur_t, 1'b0); silence(SL);
    frame(1'b1, 1'b1, 1'b0, 1'b0, cur_t, 1'b0); silence(SL);
    cur_t = ~cur_t;
    frame(1'b0, cur_t, 1'b0, 1'b0, cur_t, 1'b0); silence(SL);
    frame(1'b0, 1'b0, 1'b0, 1'b0, cur_t, 1'b0); silence(SL);
    frame(1'b1, 1'b1, 1'b1, 1'b1, cur_t, 1'b0); silence(SL);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule